// File: doc/BRIEF.md
# Derandomizer Occupancy Emulating Trigger Gate

This block is the central gate for first-level trigger accepts. Front-end derandomizer FIFOs each hold a guaranteed minimum number of events, and each event is read out in a fixed number of clock cycles. The gate does not observe any FIFO. It keeps its own predicted occupancy. Each forwarded accept adds one event to that count, and one event is removed every readout interval while the count is non-zero. A request is forwarded only when the prediction shows space. The usable depth is kept one event below the physical guarantee, as a margin for uncertainty in the individual implementations.

An external throttle input lets the next trigger level hold back every accept while it is high. Accepts in consecutive cycles pass as long as space remains, so a full-depth burst of back-to-back triggers is admitted. Each request produces exactly one of two registered pulses, accept or veto. The modelled occupancy count is driven out alongside them.

Top module: `occ_emul_trig_gate`

## Requirements
- R1: A synchronous active-high reset sets the occupancy output to 0, clears the readout interval timer, and holds the accept and veto outputs low.
- R2: The usable depth is PHYS_DEPTH minus MARGIN (16 - 1 = 15 by default). The occupancy output, a 5-bit unsigned count by default, never exceeds it, and a request made while the count equals it is vetoed.
- R3: A request with throttle low and occupancy below the usable depth gives an accept pulse in the next cycle, and the occupancy rises by one in that same cycle. Requests on consecutive cycles are each accepted while space remains, so 15 back-to-back requests from empty all pass.
- R4: While the throttle input is high, every request is vetoed and the occupancy is not increased.
- R5: Each request yields exactly one registered pulse, accept or veto, one cycle after the request. A cycle with no request yields neither pulse.
- R6: While occupancy is non-zero, one event is removed every READOUT_CYCLES cycles (36 by default). The first removal comes READOUT_CYCLES cycles after the count leaves zero, and later removals follow back to back at the same spacing.
- R7: An accept and a removal in the same cycle leave the occupancy unchanged.
- R8: An empty model removes nothing and stays at 0. The interval timing starts again from the cycle in which the count next becomes non-zero.
- R9: A request made while the count equals the usable depth is vetoed even in the cycle in which a removal takes place, and the occupancy then falls by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_req_i | input | 1 | First-level trigger accept request for this cycle |
| throttle_i | input | 1 | Hold-off level from the next trigger level |
| accept_o | output | 1 | Registered pulse: request forwarded |
| veto_o | output | 1 | Registered pulse: request refused |
| occupancy_o | output | CNT_W ($clog2(PHYS_DEPTH+1)) | Modelled events held in the front-end buffers |

## Verification
The bench builds the gate with a physical depth of 16, a margin of 1 and a readout interval of 36 cycles. These are the operating values, and they keep a full 15-event burst and three successive removals within about 110 cycles. With those settings the bench reaches the full-depth boundary, a refusal in the same cycle as a removal, and an accept that cancels a removal. After a reset it drains a lone event and checks that the empty model stays idle for a long quiet stretch, and that the timing restarts when a new event arrives.

// File: rtl/occ_gate_pkg.sv
`timescale 1ns/1ps
package occ_gate_pkg;

  // Outcome of one trigger request in a cycle
  typedef enum logic [1:0] {
    ADM_IDLE = 2'b00,
    ADM_PASS = 2'b01,
    ADM_VETO = 2'b10
  } adm_t;

endpackage

// File: rtl/occ_admit_decide.sv
`timescale 1ns/1ps
module occ_admit_decide
  import occ_gate_pkg::*;
(
  input  logic trig_req,
  input  logic throttle,
  input  logic full,
  output adm_t verdict
);

  always_comb begin
    if (!trig_req)
      verdict = ADM_IDLE;
    else if (throttle || full)
      verdict = ADM_VETO;
    else
      verdict = ADM_PASS;
  end

endmodule

// File: rtl/occ_level_ctr.sv
`timescale 1ns/1ps
module occ_level_ctr #(
  parameter int CNT_W = 5,
  parameter int LIMIT = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] level,
  output logic             full,
  output logic             busy
);

  localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(LIMIT);

  logic [CNT_W-1:0] level_q;
  logic             dec_ok;

  // never go below zero even if asked
  assign dec_ok = dec && (level_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= '0;
    end else begin
      case ({inc, dec_ok})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
    end
  end

  assign level = level_q;
  assign full  = (level_q >= LIMIT_V);
  assign busy  = (level_q != '0);

endmodule

// File: rtl/occ_drain_timer.sv
`timescale 1ns/1ps
module occ_drain_timer #(
  parameter int INTERVAL = 36
) (
  input  logic clk,
  input  logic rst,
  input  logic busy,
  output logic drain
);

  generate
    if (INTERVAL <= 1) begin : g_every_cycle
      // one event leaves each cycle while anything is held
      assign drain = busy;
    end else begin : g_counted
      localparam int TW = $clog2(INTERVAL);
      localparam logic [TW-1:0] LAST = TW'(INTERVAL - 1);

      logic [TW-1:0] tick_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          tick_q <= '0;
        end else if (!busy) begin
          tick_q <= '0;
        end else if (tick_q == LAST) begin
          tick_q <= '0;
        end else begin
          tick_q <= tick_q + 1'b1;
        end
      end

      assign drain = busy && (tick_q == LAST);
    end
  endgenerate

endmodule

// File: rtl/occ_emul_trig_gate.sv
`timescale 1ns/1ps
module occ_emul_trig_gate
  import occ_gate_pkg::*;
#(
  parameter int PHYS_DEPTH    = 16,
  parameter int MARGIN        = 1,
  parameter int READOUT_CYCLES = 36,
  localparam int CNT_W        = $clog2(PHYS_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig_req_i,
  input  logic             throttle_i,
  output logic             accept_o,
  output logic             veto_o,
  output logic [CNT_W-1:0] occupancy_o
);

  localparam int LIMIT = PHYS_DEPTH - MARGIN;

  adm_t             verdict;
  logic             full_w;
  logic             busy_w;
  logic             drain_w;
  logic             pass_w;
  logic [CNT_W-1:0] level_w;
  logic             accept_q;
  logic             veto_q;

  occ_admit_decide u_decide (
    .trig_req (trig_req_i),
    .throttle (throttle_i),
    .full     (full_w),
    .verdict  (verdict)
  );

  assign pass_w = (verdict == ADM_PASS);

  occ_level_ctr #(
    .CNT_W (CNT_W),
    .LIMIT (LIMIT)
  ) u_level (
    .clk   (clk),
    .rst   (rst),
    .inc   (pass_w),
    .dec   (drain_w),
    .level (level_w),
    .full  (full_w),
    .busy  (busy_w)
  );

  occ_drain_timer #(
    .INTERVAL (READOUT_CYCLES)
  ) u_timer (
    .clk   (clk),
    .rst   (rst),
    .busy  (busy_w),
    .drain (drain_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      accept_q <= 1'b0;
      veto_q   <= 1'b0;
    end else begin
      accept_q <= pass_w;
      veto_q   <= (verdict == ADM_VETO);
    end
  end

  assign accept_o    = accept_q;
  assign veto_o      = veto_q;
  assign occupancy_o = level_w;

endmodule

// File: rtl/occ_gate_chk.sv
`timescale 1ns/1ps
module occ_gate_chk #(
  parameter int LIMIT    = 15,
  parameter int INTERVAL = 36,
  parameter int CNT_W    = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             trig_req_i,
  input logic             throttle_i,
  input logic             accept_o,
  input logic             veto_o,
  input logic [CNT_W-1:0] occupancy_o,
  input logic             drain
);

  logic        past_ok_q;
  logic [31:0] since_q;

  always_ff @(posedge clk) begin
    past_ok_q <= !rst;
  end

  // cycles since the last removal, saturating at the interval
  always_ff @(posedge clk) begin
    if (rst)
      since_q <= 32'(INTERVAL);
    else if (drain)
      since_q <= '0;
    else if (since_q < 32'(INTERVAL))
      since_q <= since_q + 1;
  end

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
    32'(occupancy_o) <= 32'(LIMIT));

  p_grant_r3: assert property (@(posedge clk) disable iff (rst)
    past_ok_q && $past(trig_req_i && !throttle_i && (32'(occupancy_o) < 32'(LIMIT)))
    |-> accept_o);

  p_throttle_r4: assert property (@(posedge clk) disable iff (rst)
    past_ok_q && $past(throttle_i) |-> !accept_o);

  p_one_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    past_ok_q && $past(trig_req_i) |-> (accept_o != veto_o));

  p_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    past_ok_q && !$past(trig_req_i) |-> (!accept_o && !veto_o));

  p_spacing_r6: assert property (@(posedge clk) disable iff (rst)
    drain |-> since_q >= 32'(INTERVAL - 1));

  p_cancel_r7: assert property (@(posedge clk) disable iff (rst)
    past_ok_q && accept_o && $past(drain) |-> occupancy_o == $past(occupancy_o));

  p_empty_r8: assert property (@(posedge clk) disable iff (rst)
    (occupancy_o == '0) |-> !drain);

endmodule

bind occ_emul_trig_gate occ_gate_chk #(
  .LIMIT    (PHYS_DEPTH - MARGIN),
  .INTERVAL (READOUT_CYCLES),
  .CNT_W    (CNT_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .trig_req_i  (trig_req_i),
  .throttle_i  (throttle_i),
  .accept_o    (accept_o),
  .veto_o      (veto_o),
  .occupancy_o (occupancy_o),
  .drain       (drain_w)
);

// File: tb/tb_occ_emul_trig_gate.sv
`timescale 1ns/1ps
module tb_occ_emul_trig_gate;

  localparam int NV = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req = 1'b0;
  logic       thr = 1'b0;
  logic       acc;
  logic       vet;
  logic [4:0] occ;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  occ_emul_trig_gate #(
    .PHYS_DEPTH     (16),
    .MARGIN         (1),
    .READOUT_CYCLES (36)
  ) dut (
    .clk         (clk),
    .rst         (rst),
    .trig_req_i  (req),
    .throttle_i  (thr),
    .accept_o    (acc),
    .veto_o      (vet),
    .occupancy_o (occ)
  );

  // {req, throttle, expected accept, expected veto, expected occupancy}
  localparam logic [8:0] VEC [NV] = '{
    {1'b1,1'b0,1'b1,1'b0,5'd1},  {1'b1,1'b0,1'b1,1'b0,5'd2},
    {1'b1,1'b0,1'b1,1'b0,5'd3},  {1'b1,1'b0,1'b1,1'b0,5'd4},
    {1'b1,1'b0,1'b1,1'b0,5'd5},  {1'b1,1'b0,1'b1,1'b0,5'd6},
    {1'b1,1'b0,1'b1,1'b0,5'd7},  {1'b1,1'b0,1'b1,1'b0,5'd8},
    {1'b1,1'b0,1'b1,1'b0,5'd9},  {1'b1,1'b0,1'b1,1'b0,5'd10},
    {1'b1,1'b0,1'b1,1'b0,5'd11}, {1'b1,1'b0,1'b1,1'b0,5'd12},
    {1'b1,1'b0,1'b1,1'b0,5'd13}, {1'b1,1'b0,1'b1,1'b0,5'd14},
    {1'b1,1'b0,1'b1,1'b0,5'd15}, {1'b1,1'b0,1'b0,1'b1,5'd15},
    {1'b0,1'b1,1'b0,1'b0,5'd15}, {1'b1,1'b1,1'b0,1'b1,5'd15},
    {1'b0,1'b0,1'b0,1'b0,5'd15}, {1'b1,1'b1,1'b0,1'b1,5'd15}
  };

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag, input int ea, input int ev, input int eo);
    check({tag, " accept"}, int'(acc), ea);
    check({tag, " veto"}, int'(vet), ev);
    check({tag, " occupancy"}, int'(occ), eo);
  endtask

  // drive at the falling edge, sample mid-cycle after the rising edge
  task automatic step(input logic r, input logic t);
    @(negedge clk);
    req = r;
    thr = t;
    @(posedge clk);
    #5;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    req = 1'b0;
    thr = 1'b0;
    repeat (3) @(posedge clk);
    #5;
    check_all("R1 reset", 0, 0, 0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();

    // R3 burst of 15, R2 refusal at the limit, R4 throttle, R5 pulses
    for (int k = 0; k < NV; k++) begin
      step(VEC[k][8], VEC[k][7]);
      check_all($sformatf("R2/R3/R4/R5 vector %0d", k),
                int'(VEC[k][6]), int'(VEC[k][5]), int'(VEC[k][4:0]));
    end

    // edges 20..35: still full, no removal yet (R6)
    idle(16);
    check("R6 before first removal", int'(occ), 15);
    idle(1);  // edge 36
    check("R6 first removal", int'(occ), 14);
    step(1'b1, 1'b0);  // edge 37: space again
    check_all("R3 accept after removal", 1, 0, 15);
    idle(34);  // edges 38..71
    check("R6 holds until next interval", int'(occ), 15);
    step(1'b1, 1'b0);  // edge 72: full, removal in same cycle
    check_all("R9 veto at limit during removal", 0, 1, 14);
    idle(35);  // edges 73..107
    check("R6 steady between removals", int'(occ), 14);
    step(1'b1, 1'b0);  // edge 108: accept cancels removal
    check_all("R7 accept and removal cancel", 1, 0, 14);
    step(1'b1, 1'b1);  // throttle with space
    check_all("R4 throttle with space", 0, 1, 14);

    do_reset();

    // lone event drains after exactly the interval (R6)
    step(1'b1, 1'b0);
    check_all("R3 lone accept", 1, 0, 1);
    idle(35);
    check("R6 lone event still held", int'(occ), 1);
    idle(1);
    check("R6 lone event removed", int'(occ), 0);

    // empty stays empty (R8)
    for (int i = 0; i < 40; i++) begin
      step(1'b0, 1'b0);
      if (occ != 5'd0 || acc || vet)
        check("R8 empty model idle", int'(occ), 0);
    end
    check_all("R8 empty after quiet stretch", 0, 0, 0);

    // timing restarts from the new arrival (R8)
    idle(7);
    step(1'b1, 1'b0);
    check_all("R8 restart accept", 1, 0, 1);
    idle(35);
    check("R8 restart held full interval", int'(occ), 1);
    idle(1);
    check("R8 restart removal", int'(occ), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule